// File: doc/BRIEF.md
# Data Cache Maintenance Command Engine

This block is the maintenance half of a small write-back, set-associative data cache that is indexed with virtual address bits and tagged with physical address bits. Software drives it through a narrow auxiliary register bus. It runs four commands: write back the whole cache, invalidate the whole cache, write back one line and invalidate one line. The block holds the tag, valid and dirty state of every line in a register array. Each dirty line that has to reach memory goes out on a write-back request port with a valid/ready handshake.

Invalidation has two behaviours, chosen by a mode bit in the control register. With the bit clear, dirty data is dropped. With it set, every dirty line is written back before it is invalidated. Per-line commands find their line in one of two ways, also chosen by a control bit. In tag-register addressing, the physical tag comes from a separate tag register and the set index comes from the command word. In packed addressing, the command word carries the physical address, and its low bits hold the virtual index bits that lie above the page offset.

The refill side of the cache writes lines into the array through a fill port and reads them back through a lookup port. Data storage and the normal load/store path sit outside this block.

Top module: `dcache_maint`

## Requirements
- R1: After reset, control register bit 0 (disable) reads 1 and `cache_en` is 0. `cache_en` always equals the inverse of that bit.
- R2: After reset, control bit 1 (write-back-on-invalidate) and control bit 2 (packed addressing) read 0. Both bits read back what was last written to them.
- R3: Writing a value with bit 0 set to register 1 starts a whole-cache flush. The walk goes through sets in ascending order and, inside each set, through ways in ascending order. Every valid dirty line is sent as one write-back with address {tag, set[2:0], 5'b0}, and afterwards the line is valid and clean. Clean and invalid lines are left as they were.
- R4: Writing a value with bit 0 set to register 2 with control bit 1 at 0 invalidates every line and produces no write-back.
- R5: The same command with control bit 1 at 1 first writes back each valid dirty line, in the walk order of R3, and then invalidates every line.
- R6: Control bit 8 (busy) reads 1 from the cycle after a command is accepted until the command finishes. With `wb_ready` held high, a whole-cache command keeps it set for SETS*WAYS cycles and a per-line command for WAYS cycles.
- R7: A write-back request stays asserted with a stable address until `wb_ready` is seen. The walk does not move past that line until then, and a command cannot finish with a request still open.
- R8: Per-line commands are written to register 3 (flush) and register 4 (invalidate). In tag-register addressing (control bit 2 = 0), the set comes from command bits [9:5] and the tag from bits [31:8] of register 5. Command bits [4:0] are ignored. Only a valid way whose tag matches is acted on.
- R9: A per-line command whose tag matches no valid way in the set changes nothing and produces no write-back.
- R10: In packed addressing (control bit 2 = 1), the set is {cmd[1:0], cmd[7:5]} and the tag is cmd[31:8].
- R11: Command writes made while busy is 1 are ignored. So are whole-cache command writes whose bit 0 is 0.
- R12: While the block is idle, `fill_en` writes valid, tag and dirty into the chosen set and way. The fill is ignored while busy is 1. The lookup port returns the stored state of the set and way it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_addr | input | 4 | Register number |
| aux_wdata | input | 32 | Register write data |
| aux_we | input | 1 | Register write strobe |
| aux_rdata | output | 32 | Register read data (combinational) |
| cache_en | output | 1 | Cache enabled |
| fill_en | input | 1 | Refill-side line write |
| fill_set | input | 5 | Fill set index |
| fill_way | input | 1 | Fill way |
| fill_tag | input | 24 | Fill physical tag |
| fill_dirty | input | 1 | Fill dirty flag |
| look_set | input | 5 | Lookup set index |
| look_way | input | 1 | Lookup way |
| look_valid | output | 1 | Looked-up line valid |
| look_dirty | output | 1 | Looked-up line dirty |
| look_tag | output | 24 | Looked-up line tag |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | 32 | Write-back physical line address |

## Verification
The assertions check the handshake on every cycle: an open write-back request must hold its address until it is accepted, no request may appear outside a command, busy may only rise after a register write, and a command may not finish while a request is still open. Several things only show up in the bench's scenarios against its behavioural model of the array. These are the walk order and the address of each write-back, the final clean or invalid state of the lines, the choice between dropping and writing back, the index and tag taken in each addressing mode, the exact busy durations, and the commands and fills that are ignored while busy.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [0:0] {
    OP_FLUSH = 1'b0,
    OP_INV   = 1'b1
  } dcm_op_e;

  localparam logic [3:0] REG_CTRL       = 4'd0;
  localparam logic [3:0] REG_FLUSH_ALL  = 4'd1;
  localparam logic [3:0] REG_INV_ALL    = 4'd2;
  localparam logic [3:0] REG_FLUSH_LINE = 4'd3;
  localparam logic [3:0] REG_INV_LINE   = 4'd4;
  localparam logic [3:0] REG_PTAG       = 4'd5;

  localparam int CTRL_DIS_BIT    = 0;
  localparam int CTRL_WBINV_BIT  = 1;
  localparam int CTRL_PACKED_BIT = 2;
  localparam int CTRL_BUSY_BIT   = 8;

endpackage

// File: rtl/dcm_regs.sv
module dcm_regs
  import dcm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 5,
  parameter int OFF_W    = 5,
  parameter int PG_SHIFT = 8,
  parameter int TAG_W    = 24,
  parameter int ALIAS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        aux_addr,
  input  logic [ADDR_W-1:0] aux_wdata,
  input  logic              aux_we,
  output logic [ADDR_W-1:0] aux_rdata,
  input  logic              busy,
  output logic              cache_en,
  output logic              start,
  output dcm_op_e           start_op,
  output logic              start_whole,
  output logic              start_wbmode,
  output logic [IDX_W-1:0]  start_set,
  output logic [TAG_W-1:0]  start_tag
);

  logic             dis_q, dis_d;
  logic             wbinv_q, wbinv_d;
  logic             packed_q, packed_d;
  logic [TAG_W-1:0] ptag_q, ptag_d;
  logic             ctrl_wr, ptag_wr;
  logic [IDX_W-1:0] tagreg_set, packed_set;
  logic             unused_wdata;

  assign ctrl_wr      = aux_we && (aux_addr == REG_CTRL);
  assign ptag_wr      = aux_we && (aux_addr == REG_PTAG);
  assign unused_wdata = ^aux_wdata;

  // Control and tag register next state
  always_comb begin
    dis_d    = dis_q;
    wbinv_d  = wbinv_q;
    packed_d = packed_q;
    ptag_d   = ptag_q;
    if (ctrl_wr) begin
      dis_d    = aux_wdata[CTRL_DIS_BIT];
      wbinv_d  = aux_wdata[CTRL_WBINV_BIT];
      packed_d = aux_wdata[CTRL_PACKED_BIT];
    end
    if (ptag_wr) begin
      ptag_d = aux_wdata[ADDR_W-1:PG_SHIFT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q    <= 1'b1;
      wbinv_q  <= 1'b0;
      packed_q <= 1'b0;
    end else if (ctrl_wr) begin
      dis_q    <= dis_d;
      wbinv_q  <= wbinv_d;
      packed_q <= packed_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ptag_wr) begin
      ptag_q <= ptag_d;
    end
  end

  assign cache_en = ~dis_q;

  // Line index decode for the two addressing modes
  assign tagreg_set = aux_wdata[OFF_W+IDX_W-1:OFF_W];

  generate
    if (ALIAS_W > 0) begin : g_alias
      assign packed_set = {aux_wdata[ALIAS_W-1:0], aux_wdata[PG_SHIFT-1:OFF_W]};
    end else begin : g_noalias
      assign packed_set = aux_wdata[OFF_W+IDX_W-1:OFF_W];
    end
  endgenerate

  // Command decode: accepted only while idle
  always_comb begin
    start        = 1'b0;
    start_op     = OP_FLUSH;
    start_whole  = 1'b0;
    start_wbmode = wbinv_q;
    start_set    = packed_q ? packed_set : tagreg_set;
    start_tag    = packed_q ? aux_wdata[ADDR_W-1:PG_SHIFT] : ptag_q;
    if (aux_we && !busy) begin
      case (aux_addr)
        REG_FLUSH_ALL: begin
          start       = aux_wdata[0];
          start_whole = 1'b1;
        end
        REG_INV_ALL: begin
          start       = aux_wdata[0];
          start_whole = 1'b1;
          start_op    = OP_INV;
        end
        REG_FLUSH_LINE: begin
          start = 1'b1;
        end
        REG_INV_LINE: begin
          start    = 1'b1;
          start_op = OP_INV;
        end
        default: begin
          start = 1'b0;
        end
      endcase
    end
  end

  // Read mux
  always_comb begin
    aux_rdata = '0;
    case (aux_addr)
      REG_CTRL: begin
        aux_rdata[CTRL_DIS_BIT]    = dis_q;
        aux_rdata[CTRL_WBINV_BIT]  = wbinv_q;
        aux_rdata[CTRL_PACKED_BIT] = packed_q;
        aux_rdata[CTRL_BUSY_BIT]   = busy;
      end
      REG_PTAG: begin
        aux_rdata = {ptag_q, {PG_SHIFT{1'b0}}};
      end
      default: begin
        aux_rdata = '0;
      end
    endcase
  end

endmodule

// File: rtl/dcm_tag_array.sv
module dcm_tag_array #(
  parameter int SETS  = 32,
  parameter int WAYS  = 2,
  parameter int TAG_W = 24,
  parameter int IDX_W = 5,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             upd_inval,
  input  logic [IDX_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  output logic             a_valid,
  output logic             a_dirty,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  output logic             b_valid,
  output logic             b_dirty,
  output logic [TAG_W-1:0] b_tag
);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  dirty_d [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic             state_en;

  assign state_en = wr_en | upd_en;

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (wr_en) begin
      valid_d[wr_set][wr_way] = 1'b1;
      dirty_d[wr_set][wr_way] = wr_dirty;
    end
    if (upd_en) begin
      dirty_d[upd_set][upd_way] = 1'b0;
      if (upd_inval) begin
        valid_d[upd_set][upd_way] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (state_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  assign a_valid = valid_q[a_set][a_way];
  assign a_dirty = dirty_q[a_set][a_way];
  assign a_tag   = tag_q[a_set][a_way];
  assign b_valid = valid_q[b_set][b_way];
  assign b_dirty = dirty_q[b_set][b_way];
  assign b_tag   = tag_q[b_set][b_way];

endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
  import dcm_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int WAYS  = 2,
  parameter int TAG_W = 24,
  parameter int IDX_W = 5,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  dcm_op_e          start_op,
  input  logic             start_whole,
  input  logic             start_wbmode,
  input  logic [IDX_W-1:0] start_set,
  input  logic [TAG_W-1:0] start_tag,
  output logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_way,
  input  logic             rd_valid,
  input  logic             rd_dirty,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             upd_en,
  output logic [IDX_W-1:0] upd_set,
  output logic [WAY_W-1:0] upd_way,
  output logic             upd_inval,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [TAG_W-1:0] wb_tag,
  output logic [IDX_W-1:0] wb_set,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic             busy_q, busy_d;
  dcm_op_e          op_q, op_d;
  logic             whole_q, whole_d;
  logic             mode_q, mode_d;
  logic [IDX_W-1:0] set_q, set_d;
  logic [WAY_W-1:0] way_q, way_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             hit, need_wb, step, last_way, done, load, dp_en;

  assign hit      = rd_valid & (whole_q | (rd_tag == tag_q));
  assign need_wb  = hit & rd_dirty & ((op_q == OP_FLUSH) | mode_q);
  assign step     = busy_q & (~need_wb | wb_ready);
  assign last_way = (way_q == LAST_WAY);
  assign done     = step & last_way & (~whole_q | (set_q == LAST_SET));
  assign load     = start & ~busy_q;
  assign dp_en    = load | step;

  always_comb begin
    busy_d  = busy_q;
    op_d    = op_q;
    whole_d = whole_q;
    mode_d  = mode_q;
    set_d   = set_q;
    way_d   = way_q;
    tag_d   = tag_q;
    if (load) begin
      busy_d  = 1'b1;
      op_d    = start_op;
      whole_d = start_whole;
      mode_d  = start_wbmode;
      set_d   = start_whole ? '0 : start_set;
      way_d   = '0;
      tag_d   = start_tag;
    end else if (step) begin
      if (done) begin
        busy_d = 1'b0;
      end else if (last_way) begin
        way_d = '0;
        set_d = set_q + IDX_W'(1);
      end else begin
        way_d = way_q + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dp_en) begin
      op_q    <= op_d;
      whole_q <= whole_d;
      mode_q  <= mode_d;
      set_q   <= set_d;
      way_q   <= way_d;
      tag_q   <= tag_d;
    end
  end

  assign rd_set    = set_q;
  assign rd_way    = way_q;
  assign upd_en    = step & hit & ((op_q == OP_INV) | need_wb);
  assign upd_set   = set_q;
  assign upd_way   = way_q;
  assign upd_inval = (op_q == OP_INV);
  assign wb_valid  = busy_q & need_wb;
  assign wb_tag    = rd_tag;
  assign wb_set    = set_q;
  assign busy      = busy_q;

endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
  import dcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 32,
  parameter int PG_SHIFT   = 8,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        aux_addr,
  input  logic [ADDR_W-1:0] aux_wdata,
  input  logic              aux_we,
  output logic [ADDR_W-1:0] aux_rdata,
  output logic              cache_en,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_dirty,
  input  logic [IDX_W-1:0]  look_set,
  input  logic [WAY_W-1:0]  look_way,
  output logic              look_valid,
  output logic              look_dirty,
  output logic [TAG_W-1:0]  look_tag,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int ALIAS_W = OFF_W + IDX_W - PG_SHIFT;
  localparam int LOIDX_W = PG_SHIFT - OFF_W;

  logic             busy;
  logic             start, start_whole, start_wbmode;
  dcm_op_e          start_op;
  logic [IDX_W-1:0] start_set;
  logic [TAG_W-1:0] start_tag;
  logic [IDX_W-1:0] rd_set, upd_set, wb_set;
  logic [WAY_W-1:0] rd_way, upd_way;
  logic             rd_valid, rd_dirty;
  logic [TAG_W-1:0] rd_tag, wb_tag;
  logic             upd_en, upd_inval, fill_ok;
  logic             unused_set;

  assign fill_ok    = fill_en & ~busy;
  assign unused_set = ^wb_set;

  dcm_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .PG_SHIFT(PG_SHIFT), .TAG_W(TAG_W), .ALIAS_W(ALIAS_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_we(aux_we),
    .aux_rdata(aux_rdata), .busy(busy), .cache_en(cache_en),
    .start(start), .start_op(start_op), .start_whole(start_whole),
    .start_wbmode(start_wbmode), .start_set(start_set), .start_tag(start_tag)
  );

  dcm_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_ok), .wr_set(fill_set), .wr_way(fill_way),
    .wr_tag(fill_tag), .wr_dirty(fill_dirty),
    .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_inval(upd_inval),
    .a_set(rd_set), .a_way(rd_way),
    .a_valid(rd_valid), .a_dirty(rd_dirty), .a_tag(rd_tag),
    .b_set(look_set), .b_way(look_way),
    .b_valid(look_valid), .b_dirty(look_dirty), .b_tag(look_tag)
  );

  dcm_walker #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_op(start_op), .start_whole(start_whole),
    .start_wbmode(start_wbmode), .start_set(start_set), .start_tag(start_tag),
    .rd_set(rd_set), .rd_way(rd_way),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_inval(upd_inval),
    .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_tag(wb_tag), .wb_set(wb_set), .busy(busy)
  );

  assign wb_addr = {wb_tag, wb_set[LOIDX_W-1:0], {OFF_W{1'b0}}};

endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aux_we,
  input logic              busy,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr
);

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  // R6
  wb_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);

  // R6
  busy_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(aux_we));

  // R7
  no_open_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!$past(wb_valid) || $past(wb_ready)));

endmodule

bind dcache_maint dcm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .aux_we(aux_we), .busy(busy),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
);

// File: tb/test_dcache_maint.sv
`timescale 1ns/1ps
module test_dcache_maint;

  localparam int NS = 32;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  aux_addr;
  logic [31:0] aux_wdata;
  logic        aux_we;
  logic [31:0] aux_rdata;
  logic        cache_en;
  logic        fill_en;
  logic [4:0]  fill_set;
  logic [0:0]  fill_way;
  logic [23:0] fill_tag;
  logic        fill_dirty;
  logic [4:0]  look_set;
  logic [0:0]  look_way;
  logic        look_valid, look_dirty;
  logic [23:0] look_tag;
  logic        wb_valid;
  logic        wb_ready;
  logic [31:0] wb_addr;

  int n_chk = 0;
  int n_fail = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  bit          m_v [NS][NW];
  bit          m_d [NS][NW];
  logic [23:0] m_t [NS][NW];
  logic [31:0] exp_q [$];

  always #2.5 clk = ~clk;

  dcache_maint i_dcache_maint (
    .clk(clk), .rst_n(rst_n),
    .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_we(aux_we),
    .aux_rdata(aux_rdata), .cache_en(cache_en),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
    .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .look_set(look_set), .look_way(look_way),
    .look_valid(look_valid), .look_dirty(look_dirty), .look_tag(look_tag),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Write-back monitor: drives ready, compares every handshake with the model queue
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: wb_ready = 1'b1;
      1: wb_ready = lfsr[0];
      default: wb_ready = 1'b0;
    endcase
    if (rst_n) begin
      if (prev_stall) begin
        // R7 request held with stable address
        chk(wb_valid && (wb_addr == prev_addr), "R7 hold", wb_addr, prev_addr);
      end
      if (wb_valid && wb_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write-back", wb_addr, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(wb_addr == e, "R3 write-back address", wb_addr, e);
        end
      end
      prev_stall = wb_valid && !wb_ready;
      prev_addr  = wb_addr;
    end
  end

  task automatic aux_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    aux_addr  = a;
    aux_wdata = d;
    aux_we    = 1'b1;
    @(negedge clk);
    aux_we    = 1'b0;
    aux_addr  = 4'd0;
  endtask

  task automatic fill_raw(input int s, input int w, input logic [23:0] t, input bit d);
    @(negedge clk);
    fill_en    = 1'b1;
    fill_set   = 5'(s);
    fill_way   = 1'(w);
    fill_tag   = t;
    fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic fill(input int s, input int w, input logic [23:0] t, input bit d);
    fill_raw(s, w, t, d);
    m_v[s][w] = 1'b1;
    m_d[s][w] = d;
    m_t[s][w] = t;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    #1;
    while (aux_rdata[8] && cnt < 20000) begin
      cnt++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic void model_cmd(input bit whole, input bit inv, input bit mode,
                                    input int s0, input logic [23:0] tg);
    int s_lo = whole ? 0 : s0;
    int s_hi = whole ? NS - 1 : s0;
    for (int s = s_lo; s <= s_hi; s++) begin
      for (int w = 0; w < NW; w++) begin
        bit hit  = m_v[s][w] && (whole || m_t[s][w] == tg);
        bit need = hit && m_d[s][w] && (!inv || mode);
        if (need) exp_q.push_back({m_t[s][w], 3'(s), 5'b0});
        if (hit) begin
          if (inv) m_v[s][w] = 1'b0;
          if (inv || need) m_d[s][w] = 1'b0;
        end
      end
    end
  endfunction

  task automatic check_array(input string req);
    int bad = 0;
    logic [31:0] act_w = '0, exp_w = '0;
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        look_set = 5'(s);
        look_way = 1'(w);
        #0.1;
        if (look_valid !== m_v[s][w] ||
            (m_v[s][w] && (look_dirty !== m_d[s][w] || look_tag !== m_t[s][w]))) begin
          if (bad == 0) begin
            act_w = {look_tag, 5'(s), look_way, look_valid, look_dirty};
            exp_w = {m_t[s][w], 5'(s), 1'(w), m_v[s][w], m_d[s][w]};
          end
          bad++;
        end
      end
    end
    chk(bad == 0, req, act_w, exp_w);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    aux_addr = 4'd0; aux_wdata = '0; aux_we = 1'b0;
    fill_en = 1'b0; fill_set = '0; fill_way = '0; fill_tag = '0; fill_dirty = 1'b0;
    look_set = '0; look_way = '0; wb_ready = 1'b1;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_t[s][w] = '0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;

    // Reset state
    chk(aux_rdata == 32'h1, "R1 R2 reset control value", aux_rdata, 32'h1);
    chk(cache_en == 1'b0, "R1 reset cache_en", 32'(cache_en), 32'h0);
    chk(wb_valid == 1'b0, "R7 idle request", 32'(wb_valid), 32'h0);
    check_array("R12 array empty after reset");

    aux_wr(4'd0, 32'h0);
    #1;
    chk(cache_en == 1'b1, "R1 enable", 32'(cache_en), 32'h1);
    aux_wr(4'd0, 32'h6);
    #1;
    chk(aux_rdata == 32'h6, "R2 readback", aux_rdata, 32'h6);
    aux_wr(4'd0, 32'h0);

    // Whole flush
    fill(0, 0, 24'h000011, 1'b1);
    fill(0, 1, 24'h000022, 1'b0);
    fill(5, 1, 24'h0ABCDE, 1'b1);
    fill(31, 0, 24'h000003, 1'b1);
    fill(31, 1, 24'h000004, 1'b1);
    check_array("R12 fill while idle");
    model_cmd(1'b1, 1'b0, 1'b0, 0, '0);
    aux_wr(4'd1, 32'h1);
    wait_idle(cnt);
    chk(cnt == 64, "R6 whole flush busy cycles", cnt, 64);
    chk(exp_q.size() == 0, "R3 all write-backs seen", exp_q.size(), 0);
    check_array("R3 lines clean after flush");

    model_cmd(1'b1, 1'b0, 1'b0, 0, '0);
    aux_wr(4'd1, 32'h1);
    wait_idle(cnt);
    chk(cnt == 64, "R3 clean flush no stalls", cnt, 64);

    // Discard invalidate
    fill(2, 0, 24'h000777, 1'b1);
    fill(7, 1, 24'h000888, 1'b1);
    model_cmd(1'b1, 1'b1, 1'b0, 0, '0);
    aux_wr(4'd2, 32'h1);
    wait_idle(cnt);
    chk(cnt == 64 && exp_q.size() == 0, "R4 discard invalidate", cnt, 64);
    check_array("R4 all invalid");

    // Write-back invalidate with random back-pressure
    fill(1, 1, 24'h00AAAA, 1'b1);
    fill(3, 0, 24'h00BBBB, 1'b0);
    fill(9, 0, 24'h00CCCC, 1'b1);
    fill(9, 1, 24'h00DDDD, 1'b1);
    aux_wr(4'd0, 32'h2);
    ready_mode = 1;
    model_cmd(1'b1, 1'b1, 1'b1, 0, '0);
    aux_wr(4'd2, 32'h1);
    wait_idle(cnt);
    ready_mode = 0;
    chk(exp_q.size() == 0, "R5 write-backs before invalidate", exp_q.size(), 0);
    chk(cnt >= 64, "R7 stalls lengthen walk", cnt, 64);
    check_array("R5 all invalid");

    // Per-line ops with tag register
    aux_wr(4'd0, 32'h0);
    fill(9, 0, 24'h000A0A, 1'b1);
    fill(9, 1, 24'h000B0B, 1'b1);
    aux_wr(4'd5, {24'h000B0B, 8'h00});
    model_cmd(1'b0, 1'b0, 1'b0, 9, 24'h000B0B);
    aux_wr(4'd3, 32'h7000_0000 | (32'd9 << 5) | 32'h1F);
    wait_idle(cnt);
    chk(cnt == 2, "R6 line op busy cycles", cnt, 2);
    chk(exp_q.size() == 0, "R8 line flush write-back", exp_q.size(), 0);
    check_array("R8 only matching way cleaned");

    aux_wr(4'd5, {24'h000C0C, 8'h00});
    model_cmd(1'b0, 1'b1, 1'b0, 9, 24'h000C0C);
    aux_wr(4'd4, (32'd9 << 5));
    wait_idle(cnt);
    check_array("R9 missing line untouched");

    // Packed addressing
    aux_wr(4'd0, 32'h4);
    fill(19, 0, 24'h00D00D, 1'b1);
    fill(3, 1, 24'h00D00D, 1'b1);
    model_cmd(1'b0, 1'b1, 1'b0, 19, 24'h00D00D);
    aux_wr(4'd4, {24'h00D00D, 8'h00} | (32'd3 << 5) | 32'h2);
    wait_idle(cnt);
    check_array("R10 packed index selects set 19");
    aux_wr(4'd0, 32'h6);
    model_cmd(1'b0, 1'b1, 1'b1, 3, 24'h00D00D);
    aux_wr(4'd4, {24'h00D00D, 8'h00} | (32'd3 << 5));
    wait_idle(cnt);
    chk(exp_q.size() == 0, "R10 packed write-back invalidate", exp_q.size(), 0);
    check_array("R10 set 3 invalidated");

    // Ignored commands and fills while busy
    aux_wr(4'd0, 32'h0);
    aux_wr(4'd2, 32'h0);
    wait_idle(cnt);
    chk(cnt == 0, "R11 whole command with bit0 clear", cnt, 0);
    fill(0, 0, 24'h000123, 1'b1);
    ready_mode = 2;
    model_cmd(1'b1, 1'b0, 1'b0, 0, '0);
    aux_wr(4'd1, 32'h1);
    aux_wr(4'd2, 32'h1);
    fill_raw(4, 1, 24'h000999, 1'b1);
    #1;
    chk(aux_rdata[8] == 1'b1, "R11 still busy while stalled", 32'(aux_rdata[8]), 1);
    ready_mode = 0;
    wait_idle(cnt);
    chk(exp_q.size() == 0, "R11 flush completed", exp_q.size(), 0);
    check_array("R11 R12 busy-time writes ignored");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule